// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This peripheral holds two independent 32-bit timers that count down. Each timer can count on one of two sources. The first is a single-cycle reference tick that arrives on a dedicated input. The second is the fabric clock divided by a power of two that the timer selects for itself. All the per-timer settings sit in one shared control word: enable, auto-reload, source select and divider exponent. Each timer also has a reload register and a current-value register that software can write directly.

When an enabled timer that already shows zero receives a count tick, it expires. The expiry sets that timer's flag in a shared event status register. If auto-reload is on, the timer restarts from its reload value on the same tick. If auto-reload is off, the timer stays at zero and goes silent until software rearms it. The interrupt output is high while either flag is set. Software clears a flag by writing zero to its bit.

Software reaches the registers through a simple synchronous bus with address, write data, write strobe, read strobe and read data. Each timer is governed by a small state machine with three states:

- IDLE: the timer is disabled.
- COUNT: the timer decrements on every count tick.
- SPENT: a one-shot timer has expired and waits to be rearmed.

The transitions between them are:

- ENABLE: IDLE to COUNT.
- DISABLE: any state to IDLE.
- EXPIRE_ONESHOT: COUNT (or IDLE) to SPENT, when the timer expires with auto-reload off.
- REARM: SPENT to COUNT, when software writes the value register.

Top module: `dual_dntimer`

## Requirements
- R1: After reset every register reads 0, both timers are disabled in IDLE, and `irq` is 0.
- R2: The registers sit at these byte offsets: control 0x00, status 0x04, timer 0 reload 0x10, timer 0 value 0x14, timer 1 reload 0x18, timer 1 value 0x1C. Control keeps only its defined bits and reads back as `wdata & 0x01F8180F`. Any other offset reads 0, and `bus_rdata` is 0 whenever `bus_rd` is low. A read returns the register contents in the same cycle, before any write that happens in that cycle.
- R3: Control bit 11 (timer 0) and bit 12 (timer 1) select the count source. When the bit is set, the timer counts on `ref_tick`. When it is clear, the timer counts on the prescaled fabric clock.
  - The divider exponent d sits in bits 21:19 for timer 0 and in bits 24:22 for timer 1.
  - A free-running counter starts at 0 after reset and advances by one every cycle. The prescaled tick occurs in each cycle where the low d bits of that counter are all ones, so it comes once every 2^d cycles. With d = 0 there is a tick every cycle.
- R4: A timer is enabled by control bit 0 (timer 0) or bit 2 (timer 1). While enabled and not SPENT, its value drops by one on each count tick. While disabled, its value does not change except through a software write.
- R5: A count tick that finds an enabled timer at 0 is an expiry. If auto-reload is set (control bit 1 for timer 0, bit 3 for timer 1), the value register takes the reload value on that same tick.
- R6: When a timer expires with auto-reload clear, it stays at 0 in SPENT and raises no further flags. It leaves SPENT only when software writes its value register or disables it.
- R7: A write to a value register loads that value on the write edge. If a count tick arrives in the same cycle, the write wins: there is no decrement and no expiry.
- R8: Status bit 0 flags an expiry of timer 0 and bit 8 flags an expiry of timer 1.
  - Writing 0 to a status bit clears it.
  - Writing 1 to a status bit leaves it unchanged.
  - If an expiry and a clear land in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when at least one status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe; the write takes effect on this clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ref_tick | input | 1 | Single-cycle pulse from the fixed reference tick |
| irq | output | 1 | OR of the two status flags |

## Verification
Read data is combinational, so a register's contents can be read back in the same cycle. A write or a count tick changes the registers on the clock edge where the strobe or tick is present, so its effect shows up on a read in the next cycle. `irq` follows a status flag straight out of a register and rises right after the edge on which the expiry happened.

The bench drives its inputs on the falling edge and checks outputs one time unit later. A cycle-by-cycle model built from the requirements advances on every rising edge, which keeps each expectation tied to the correct edge. For the prescaler, the number of edges is counted exactly: over 64 consecutive edges, divide-by-32 yields exactly two ticks whatever the phase of the counter.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int N_CH   = 2;
    localparam int DIV_W  = 3;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_STAT = 'h04;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_COUNT = 2'd1,
        CH_SPENT = 2'd2
    } ch_state_e;

    function automatic int en_bit(input int c);
        return 2 * c;
    endfunction

    function automatic int rl_bit(input int c);
        return 2 * c + 1;
    endfunction

    function automatic int src_bit(input int c);
        return 11 + c;
    endfunction

    function automatic int div_lsb(input int c);
        return 19 + DIV_W * c;
    endfunction

    function automatic int stat_bit(input int c);
        return 8 * c;
    endfunction

    function automatic int off_reload(input int c);
        return 'h10 + 8 * c;
    endfunction

    function automatic int off_value(input int c);
        return 'h14 + 8 * c;
    endfunction

    function automatic logic [31:0] ctrl_mask();
        logic [31:0] m;
        m = '0;
        for (int c = 0; c < N_CH; c++) begin
            m[en_bit(c)]  = 1'b1;
            m[rl_bit(c)]  = 1'b1;
            m[src_bit(c)] = 1'b1;
            for (int k = 0; k < DIV_W; k++) m[div_lsb(c) + k] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale
    import dtmr_pkg::*;
#(
    parameter int NCH  = N_CH,
    parameter int DW_S = DIV_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH*DW_S-1:0]   div_sel,
    output logic [NCH-1:0]        tick
);
    localparam int CNT_W = (1 << DW_S) - 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_tap
        logic [CNT_W-1:0] low_mask;
        assign low_mask = ~({CNT_W{1'b1}} << div_sel[c*DW_S +: DW_S]);
        assign tick[c]  = &(cnt_q | ~low_mask);
    end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         reload_en,
    input  logic         count_tick,
    input  logic         sw_load,
    input  logic [W-1:0] sw_data,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] value,
    output logic         expire
);
    ch_state_e state_q, state_d;
    logic      active, at_zero, fire;

    assign active  = en && (state_q != CH_SPENT);
    assign at_zero = (value == '0);
    assign fire    = active && count_tick && !sw_load;
    assign expire  = fire && at_zero;

    // transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (en) state_d = (expire && !reload_en) ? CH_SPENT : CH_COUNT; // ENABLE
            CH_COUNT: if (expire && !reload_en) state_d = CH_SPENT;                   // EXPIRE_ONESHOT
            CH_SPENT: if (sw_load) state_d = CH_COUNT;                                // REARM
            default:  state_d = CH_IDLE;
        endcase
        if (!en) state_d = CH_IDLE;                                                   // DISABLE
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       value <= '0;
        else if (sw_load) value <= sw_data;
        else if (fire)    value <= at_zero ? (reload_en ? reload_val : '0) : value - 1'b1;
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sw_load) |=> $stable(value)); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q != CH_SPENT && count_tick && !sw_load && value != '0)
        |=> (value == $past(value) - 1'b1)); // R4
    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && reload_en && state_q != CH_SPENT && count_tick && !sw_load && value == '0)
        |=> (value == $past(reload_val))); // R5
    AST_SPENT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_SPENT) |-> !expire); // R6
    AST_SW_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_load |=> (value == $past(sw_data))); // R7
endmodule

// File: rtl/dual_dntimer.sv
module dual_dntimer
    import dtmr_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic          ref_tick,
    output logic          irq
);
    localparam logic [DW-1:0] CMASK = DW'(ctrl_mask());

    logic [DW-1:0]       ctrl_q;
    logic [N_CH-1:0]     flag_q;
    logic [N_CH-1:0]     expire;
    logic [N_CH-1:0]     pre_tick;
    logic [N_CH*DIV_W-1:0] div_sel;
    logic [DW-1:0]       reload_q [N_CH];
    logic [DW-1:0]       value    [N_CH];
    logic [DW-1:0]       stat_word;
    logic                wr_ctrl, wr_stat;

    assign wr_ctrl = bus_wr && (bus_addr == AW'(OFF_CTRL));
    assign wr_stat = bus_wr && (bus_addr == AW'(OFF_STAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata & CMASK;
    end

    dtmr_prescale #(.NCH(N_CH), .DW_S(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .tick    (pre_tick)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic wr_reload, wr_value, count_tick;

        assign div_sel[c*DIV_W +: DIV_W] = ctrl_q[div_lsb(c) +: DIV_W];
        assign wr_reload  = bus_wr && (bus_addr == AW'(off_reload(c)));
        assign wr_value   = bus_wr && (bus_addr == AW'(off_value(c)));
        assign count_tick = ctrl_q[src_bit(c)] ? ref_tick : pre_tick[c];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         reload_q[c] <= '0;
            else if (wr_reload) reload_q[c] <= bus_wdata;
        end

        dtmr_channel #(.W(DW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (ctrl_q[en_bit(c)]),
            .reload_en  (ctrl_q[rl_bit(c)]),
            .count_tick (count_tick),
            .sw_load    (wr_value),
            .sw_data    (bus_wdata),
            .reload_val (reload_q[c]),
            .value      (value[c]),
            .expire     (expire[c])
        );

        // a clear by writing zero loses to an expiry in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[c] <= 1'b0;
            else        flag_q[c] <= (flag_q[c] && !(wr_stat && !bus_wdata[stat_bit(c)])) || expire[c];
        end

        AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            expire[c] |=> flag_q[c]); // R8
        AST_ZERO_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stat && !bus_wdata[stat_bit(c)] && !expire[c]) |=> !flag_q[c]); // R8
        AST_ONE_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stat && bus_wdata[stat_bit(c)] && flag_q[c]) |=> flag_q[c]); // R8
    end

    always_comb begin
        stat_word = '0;
        for (int c = 0; c < N_CH; c++) stat_word[stat_bit(c)] = flag_q[c];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == AW'(OFF_CTRL)) bus_rdata = ctrl_q;
            if (bus_addr == AW'(OFF_STAT)) bus_rdata = stat_word;
            for (int c = 0; c < N_CH; c++) begin
                if (bus_addr == AW'(off_reload(c))) bus_rdata = reload_q[c];
                if (bus_addr == AW'(off_value(c)))  bus_rdata = value[c];
            end
        end
    end

    assign irq = |flag_q;

    AST_IRQ_FOLLOWS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire) |=> irq); // R9
endmodule

// File: tb/tb_dual_dntimer.sv
module tb_dual_dntimer;
    localparam logic [31:0] CMASK = 32'h01F8180F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_dntimer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ref_tick(ref_tick), .irq(irq)
    );

    // reference model built from the requirements
    logic [31:0] m_ctrl;
    logic        m_stat [2];
    logic [31:0] m_val  [2];
    logic [31:0] m_rl   [2];
    logic        m_stop [2];
    int unsigned m_cnt;

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_ctrl;
            8'h04:   return {23'd0, m_stat[1], 7'd0, m_stat[0]};
            8'h10:   return m_rl[0];
            8'h14:   return m_val[0];
            8'h18:   return m_rl[1];
            8'h1C:   return m_val[1];
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_cnt = 0;
            for (int c = 0; c < 2; c++) begin
                m_stat[c] = 0; m_val[c] = '0; m_rl[c] = '0; m_stop[c] = 0;
            end
        end else begin
            logic [31:0] nv [2];
            logic        ex [2];
            for (int c = 0; c < 2; c++) begin
                logic en, rl, src, tk, swv;
                int unsigned d, msk;
                en  = m_ctrl[2*c];
                rl  = m_ctrl[2*c+1];
                src = m_ctrl[11+c];
                d   = (m_ctrl >> (19 + 3*c)) & 32'h7;
                msk = (1 << d) - 1;
                tk  = src ? ref_tick : ((m_cnt & msk) == msk);
                swv = bus_wr && bus_addr == (8'h14 + 8'(8*c));
                nv[c] = m_val[c]; ex[c] = 0;
                if (swv) nv[c] = bus_wdata;
                else if (en && !m_stop[c] && tk) begin
                    if (m_val[c] == 0) begin
                        ex[c] = 1;
                        if (rl) nv[c] = m_rl[c];
                        else begin nv[c] = 0; m_stop[c] = 1; end
                    end else nv[c] = m_val[c] - 1;
                end
                if (swv || !en) m_stop[c] = 0;
            end
            for (int c = 0; c < 2; c++) begin
                if (bus_wr && bus_addr == 8'h04 && !bus_wdata[8*c]) m_stat[c] = 0;
                if (ex[c]) m_stat[c] = 1;
                m_val[c] = nv[c];
                if (bus_wr && bus_addr == (8'h10 + 8'(8*c))) m_rl[c] = bus_wdata;
            end
            if (bus_wr && bus_addr == 8'h00) m_ctrl = bus_wdata & CMASK;
            m_cnt = m_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 chk(tag, bus_rdata, e);
        bus_rd = 0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1;
            @(negedge clk); ref_tick = 0;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state, R2 map and unmapped offset
        rd_chk(8'h00, 0, "R1 ctrl");
        rd_chk(8'h04, 0, "R1 status");
        rd_chk(8'h14, 0, "R1 value0");
        rd_chk(8'h1C, 0, "R1 value1");
        rd_chk(8'h08, 0, "R2 unmapped");
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 control keeps defined bits only
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk(8'h00, CMASK, "R2 ctrl mask");
        wr(8'h00, 0);

        // R3 ref source, R4 decrement
        wr(8'h14, 5);
        wr(8'h00, 32'h0000_0801);
        pulses(3);
        rd_chk(8'h14, 2, "R4 value after 3 ticks");
        pulses(3);
        rd_chk(8'h14, 0, "R5 value at expiry");
        rd_chk(8'h04, 32'h1, "R8 status0 set");
        chk("R9 irq high", {31'd0, irq}, 1);
        wr(8'h04, 0);
        rd_chk(8'h04, 0, "R8 clear by zero");
        pulses(2);
        rd_chk(8'h04, 0, "R6 spent stays silent");
        wr(8'h14, 1);
        pulses(2);
        rd_chk(8'h04, 32'h1, "R6 rearm by value write");
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, 32'h1, "R8 write one keeps");
        wr(8'h04, 0);

        // R8 expiry beats clear in same cycle
        wr(8'h14, 0);
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'h04; bus_wdata = 0; ref_tick = 1;
        @(negedge clk);
        bus_wr = 0; ref_tick = 0;
        rd_chk(8'h04, 32'h1, "R8 expiry wins over clear");
        // R7 write beats tick
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'h14; bus_wdata = 7; ref_tick = 1;
        @(negedge clk);
        bus_wr = 0; ref_tick = 0;
        rd_chk(8'h14, 7, "R7 write beats tick");
        wr(8'h04, 0);

        // R5 periodic reload on timer 1
        wr(8'h18, 2);
        wr(8'h1C, 2);
        wr(8'h00, 32'h0000_100C);
        pulses(3);
        rd_chk(8'h1C, 2, "R5 reload on expiry");
        rd_chk(8'h04, 32'h100, "R8 status bit 8");
        chk("R9 irq from timer1", {31'd0, irq}, 1);
        wr(8'h04, 0);
        chk("R9 irq low", {31'd0, irq}, 0);

        // R3 divide by 32: two ticks in 64 edges
        wr(8'h00, 0);
        wr(8'h14, 100);
        wr(8'h00, 32'h0028_0001);
        repeat (63) @(negedge clk);
        rd_chk(8'h14, 98, "R3 prescale div32");

        // R4 free-running from all ones, divide by 1
        wr(8'h00, 0);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0000_0003);
        repeat (9) @(negedge clk);
        rd_chk(8'h14, 32'hFFFF_FFF5, "R4 free-running");

        // random phase against the model
        for (int i = 0; i < 6000; i++) begin
            logic [7:0] addrs [7];
            string tag;
            addrs = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h0C};
            @(negedge clk);
            ref_tick = ($urandom % 10) < 3;
            bus_wr   = ($urandom % 10) == 0;
            bus_rd   = ($urandom % 10) < 6;
            bus_addr = addrs[$urandom % 7];
            if (bus_addr == 8'h00)
                bus_wdata = $urandom & 32'h0090_180F;
            else if (($urandom % 16) == 0)
                bus_wdata = 32'hFFFF_FFFF;
            else if (bus_addr == 8'h04)
                bus_wdata = $urandom;
            else
                bus_wdata = $urandom % 12;
            #1;
            case (bus_addr)
                8'h00:        tag = "R2 ctrl";
                8'h04:        tag = "R8 status";
                8'h10, 8'h18: tag = "R5 reload";
                8'h14, 8'h1C: tag = "R4 value";
                default:      tag = "R2 unmapped";
            endcase
            chk(tag, bus_rdata, bus_rd ? exp_read(bus_addr) : 32'd0);
            chk("R9 irq", {31'd0, irq}, {31'd0, m_stat[0] | m_stat[1]});
        end
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; ref_tick = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule